// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge Unit

This block serves the three read accesses a guest makes to take or inspect virtual interrupts: an ordinary acknowledge for either interrupt group, a group-1 acknowledge reserved for non-maskable interrupts (NMIs), and a running-priority read. A separate pending selector picks the best list-register entry and says whether it may preempt. This unit uses that choice to decide which interrupt ID to return, and whether to move the entry from pending to active. It also keeps the per-group active-priority banks that an activation marks.

NMIs can only be taken through the dedicated acknowledge. When NMI handling is enabled, an ordinary acknowledge that lands on an NMI entry reports a reserved ID and leaves the entry pending. Activating an NMI entry sets a per-group NMI-active flag rather than a priority bit. The running-priority read reports priority zero with the top bit set while the group-1 NMI-active flag is raised.

Each list-register entry is `{active, pending, group, nmi, prio[7:0], vid[15:0]}`, with the most significant bit first: `vid` occupies bits 15:0, `prio` bits 23:16, `nmi` bit 24, `group` bit 25, `pending` bit 26 and `active` bit 27. IDs 1020 to 1023 are special; 1023 means spurious and 1022 means that an NMI is waiting.

Top module: `vack_unit`

## Requirements
- R1: An ordinary acknowledge returns 1023 and changes neither the list registers nor the active-priority state in either of two cases: the selection is invalid or cannot preempt, or the entry's group differs from the accessed group.
- R2: On an acknowledge hit whose `vid` is 1020 to 1023, the unit returns that `vid` and writes the entry back with `pending` cleared and every other field unchanged. The active-priority state is not touched.
- R3: When `nmi_en_i` is 1, an ordinary acknowledge hit on an entry with `nmi`=1 and a non-special `vid` returns 1022 and writes nothing.
- R4: An activation returns `vid` and writes the entry back with `pending`=0 and `active`=1, all other fields kept, at the index that was selected.
- R5: A non-NMI activation sets bit `prio >> (8-PREBITS)` of the accessed group's active-priority bank. In the flat bank vector, register k/32 holds bit k%32. Bits are only ever set, and at most one per cycle.
- R6: An activation of an entry with `nmi`=1 sets that group's NMI-active flag (`apr_nmi_o[group]`) instead of a priority bit. This covers an ordinary acknowledge while `nmi_en_i` is 0 and the NMI acknowledge.
- R7: The NMI acknowledge considers only group-1 entries. A group-0 entry, or a miss, returns 1023. A non-special entry with `nmi`=0 also returns 1023. None of these cases changes any state.
- R8: A running-priority read returns 0x8000_0000_0000_0000 while the group-1 NMI-active flag is set. Otherwise it returns the lowest set bit index k over both banks, as `k << (8-PREBITS)`, or 0xFF if no bit is set.
- R9: Each strobe yields a one-cycle `rd_valid_o` with `rd_data_o` on the next clock edge, with any list-register write and active-priority update on that same edge. Only one strobe is raised per cycle.
- R10: Synchronous reset clears both banks, both NMI-active flags, `rd_valid_o` and `lr_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req_i | input | 1 | Ordinary acknowledge strobe |
| ack_grp_i | input | 1 | Group accessed by the ordinary acknowledge |
| nmi_ack_req_i | input | 1 | Group-1 NMI acknowledge strobe |
| rpr_req_i | input | 1 | Running-priority read strobe |
| sel_valid_i | input | 1 | Pending selector found an entry |
| sel_idx_i | input | IDX_W | Index of the selected entry |
| sel_preempt_i | input | 1 | Selected entry may preempt |
| lrs_i | input | NUM_LR*28 | All list-register entries, entry i at [i*28 +: 28] |
| nmi_en_i | input | 1 | NMI handling enabled for the guest |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Returned ID or running priority |
| lr_we_o | output | 1 | List-register write-back strobe |
| lr_widx_o | output | IDX_W | Index to write back |
| lr_wdata_o | output | 28 | New entry value |
| apr_g0_o | output | 2**PREBITS | Group-0 active-priority bank |
| apr_g1_o | output | 2**PREBITS | Group-1 active-priority bank |
| apr_nmi_o | output | 2 | NMI-active flag per group |

## Verification
Every result of this unit is due exactly one clock edge after the strobe. That covers the returned ID or priority, the write-back strobe and entry, and the bank and NMI-flag updates. The bench drives a strobe on a falling edge and lets one rising edge pass. It compares all of these outputs on the next falling edge, then predicts the following operation from its own updated model. A running-priority read issued right after an activation therefore sees the bits that activation set.

// File: rtl/vack_pkg.sv
package vack_pkg;
  parameter int unsigned ID_W = 16;

  typedef struct packed {
    logic            act;
    logic            pend;
    logic            grp;
    logic            nmi;
    logic [7:0]      prio;
    logic [ID_W-1:0] vid;
  } lr_t;

  localparam int unsigned LR_W = $bits(lr_t);
  localparam logic [ID_W-1:0] ID_NMI_WAIT = ID_W'(1022);
  localparam logic [ID_W-1:0] ID_SPUR     = ID_W'(1023);

  typedef enum logic [1:0] {OP_NONE, OP_ACK, OP_NMIACK, OP_RPR} op_e;

  function automatic logic id_special(input logic [ID_W-1:0] v);
    return (v >= ID_W'(1020)) && (v <= ID_W'(1023));
  endfunction
endpackage

// File: rtl/vack_lr_mux.sv
module vack_lr_mux
  import vack_pkg::*;
#(
  parameter int unsigned NUM_LR = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic [NUM_LR*LR_W-1:0] lrs_i,
  input  logic [IDX_W-1:0]       idx_i,
  output lr_t                    ent_o
);
  lr_t ents [NUM_LR];

  for (genvar i = 0; i < NUM_LR; i++) begin : g_unpack
    assign ents[i] = lr_t'(lrs_i[i*LR_W +: LR_W]);
  end

  always_comb begin
    ent_o = '0;
    if (32'(idx_i) < NUM_LR) ent_o = ents[idx_i];
  end
endmodule

// File: rtl/vack_decide.sv
module vack_decide
  import vack_pkg::*;
(
  input  op_e             op_i,
  input  logic            acc_grp_i,
  input  logic            sel_valid_i,
  input  logic            preempt_i,
  input  logic            nmi_en_i,
  input  lr_t             ent_i,
  output logic [ID_W-1:0] ret_id_o,
  output logic            lr_we_o,
  output lr_t             lr_new_o,
  output logic            act_o,
  output logic            act_grp_o
);
  logic grp_ok, hit;

  always_comb begin
    grp_ok    = (op_i == OP_ACK) ? (ent_i.grp == acc_grp_i) : ent_i.grp;
    hit       = sel_valid_i && preempt_i && grp_ok &&
                ((op_i == OP_ACK) || (op_i == OP_NMIACK));
    ret_id_o  = ID_SPUR;
    lr_we_o   = 1'b0;
    lr_new_o  = ent_i;
    act_o     = 1'b0;
    act_grp_o = (op_i == OP_ACK) ? acc_grp_i : 1'b1;
    if (hit) begin
      if (id_special(ent_i.vid)) begin
        ret_id_o      = ent_i.vid;
        lr_we_o       = 1'b1;
        lr_new_o.pend = 1'b0;
      end else if (op_i == OP_ACK && nmi_en_i && ent_i.nmi) begin
        ret_id_o = ID_NMI_WAIT;
      end else if (op_i == OP_NMIACK && !ent_i.nmi) begin
        ret_id_o = ID_SPUR;
      end else begin
        ret_id_o      = ent_i.vid;
        lr_we_o       = 1'b1;
        lr_new_o.pend = 1'b0;
        lr_new_o.act  = 1'b1;
        act_o         = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vack_apr_bank.sv
module vack_apr_bank #(
  parameter int unsigned PREBITS = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    set_i,
  input  logic                    set_nmi_i,
  input  logic [7:0]              prio_i,
  output logic [(1<<PREBITS)-1:0] bits_o,
  output logic                    nmi_o
);
  localparam int unsigned SHIFT  = 8 - PREBITS;
  localparam int unsigned NBITS  = 1 << PREBITS;
  localparam int unsigned SLOT_W = PREBITS;

  logic [SLOT_W-1:0] slot;
  assign slot = SLOT_W'(prio_i >> SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_o <= '0;
      nmi_o  <= 1'b0;
    end else if (set_i) begin
      if (set_nmi_i) nmi_o <= 1'b1;
      else           bits_o[slot] <= 1'b1;
    end
  end

  assert_apr_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((bits_o & $past(bits_o)) == $past(bits_o)));
  assert_apr_one_new_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(bits_o & ~$past(bits_o)) <= 1));
  assert_nmi_no_bit_R6: assert property (@(posedge clk) disable iff (rst)
    (set_i && set_nmi_i) |=> (bits_o == $past(bits_o)) && nmi_o);
  initial if (NBITS > 128 || PREBITS < 5) $error("vack_apr_bank: PREBITS out of range");
endmodule

// File: rtl/vack_rpr.sv
module vack_rpr #(
  parameter int unsigned PREBITS = 5
) (
  input  logic [(1<<PREBITS)-1:0] g0_i,
  input  logic [(1<<PREBITS)-1:0] g1_i,
  input  logic                    g1_nmi_i,
  output logic [63:0]             rpr_o
);
  localparam int unsigned SHIFT = 8 - PREBITS;
  localparam int unsigned NBITS = 1 << PREBITS;

  logic [NBITS-1:0] all_bits;
  logic             found;
  logic [7:0]       prio;

  always_comb begin
    all_bits = g0_i | g1_i;
    found    = 1'b0;
    prio     = 8'hFF;
    for (int k = 0; k < NBITS; k++) begin
      if (!found && all_bits[k]) begin
        found = 1'b1;
        prio  = 8'(k << SHIFT);
      end
    end
    rpr_o = g1_nmi_i ? {1'b1, 63'd0} : {56'd0, prio};
  end
endmodule

// File: rtl/vack_unit.sv
module vack_unit
  import vack_pkg::*;
#(
  parameter int unsigned NUM_LR  = 4,
  parameter int unsigned PREBITS = 5,
  localparam int unsigned IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
  localparam int unsigned NBITS  = 1 << PREBITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ack_req_i,
  input  logic                   ack_grp_i,
  input  logic                   nmi_ack_req_i,
  input  logic                   rpr_req_i,
  input  logic                   sel_valid_i,
  input  logic [IDX_W-1:0]       sel_idx_i,
  input  logic                   sel_preempt_i,
  input  logic [NUM_LR*LR_W-1:0] lrs_i,
  input  logic                   nmi_en_i,
  output logic                   rd_valid_o,
  output logic [63:0]            rd_data_o,
  output logic                   lr_we_o,
  output logic [IDX_W-1:0]       lr_widx_o,
  output logic [LR_W-1:0]        lr_wdata_o,
  output logic [NBITS-1:0]       apr_g0_o,
  output logic [NBITS-1:0]       apr_g1_o,
  output logic [1:0]             apr_nmi_o
);
  op_e             op;
  lr_t             ent, lr_new;
  logic [ID_W-1:0] ret_id;
  logic            dec_we, act, act_grp;
  logic [63:0]     rpr_val;
  logic [NBITS-1:0] banks [2];

  always_comb begin
    if (nmi_ack_req_i)  op = OP_NMIACK;
    else if (ack_req_i) op = OP_ACK;
    else if (rpr_req_i) op = OP_RPR;
    else                op = OP_NONE;
  end

  vack_lr_mux #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_mux (
    .lrs_i(lrs_i), .idx_i(sel_idx_i), .ent_o(ent));

  vack_decide u_dec (
    .op_i(op), .acc_grp_i(ack_grp_i), .sel_valid_i(sel_valid_i),
    .preempt_i(sel_preempt_i), .nmi_en_i(nmi_en_i), .ent_i(ent),
    .ret_id_o(ret_id), .lr_we_o(dec_we), .lr_new_o(lr_new),
    .act_o(act), .act_grp_o(act_grp));

  for (genvar g = 0; g < 2; g++) begin : g_bank
    vack_apr_bank #(.PREBITS(PREBITS)) u_bank (
      .clk(clk), .rst(rst),
      .set_i(act && (act_grp == g[0])),
      .set_nmi_i(ent.nmi), .prio_i(ent.prio),
      .bits_o(banks[g]), .nmi_o(apr_nmi_o[g]));
  end
  assign apr_g0_o = banks[0];
  assign apr_g1_o = banks[1];

  vack_rpr #(.PREBITS(PREBITS)) u_rpr (
    .g0_i(apr_g0_o), .g1_i(apr_g1_o), .g1_nmi_i(apr_nmi_o[1]), .rpr_o(rpr_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      lr_we_o    <= 1'b0;
      lr_widx_o  <= '0;
      lr_wdata_o <= '0;
    end else begin
      rd_valid_o <= (op != OP_NONE);
      rd_data_o  <= (op == OP_RPR) ? rpr_val : {{(64-ID_W){1'b0}}, ret_id};
      lr_we_o    <= dec_we;
      lr_widx_o  <= sel_idx_i;
      lr_wdata_o <= lr_new;
    end
  end

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_req_i, nmi_ack_req_i, rpr_req_i}));
  assert_result_next_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_req_i || nmi_ack_req_i || rpr_req_i) |=> rd_valid_o);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !(ack_req_i || nmi_ack_req_i || rpr_req_i) |=> !rd_valid_o && !lr_we_o);
  assert_miss_spurious_R1: assert property (@(posedge clk) disable iff (rst)
    (ack_req_i && !nmi_ack_req_i &&
     !(sel_valid_i && sel_preempt_i && ent.grp == ack_grp_i))
    |=> (rd_data_o == 64'd1023) && !lr_we_o);
  assert_nmi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (ack_req_i && !nmi_ack_req_i && nmi_en_i && sel_valid_i && sel_preempt_i &&
     ent.grp == ack_grp_i && ent.nmi && !id_special(ent.vid))
    |=> (rd_data_o == 64'd1022) && !lr_we_o);
  assert_write_not_pending_R4: assert property (@(posedge clk) disable iff (rst)
    lr_we_o |-> !lr_wdata_o[LR_W-2]);
  assert_nmiack_g0_R7: assert property (@(posedge clk) disable iff (rst)
    (nmi_ack_req_i && !ent.grp) |=> (rd_data_o == 64'd1023) && !lr_we_o);
  assert_rpr_nmi_R8: assert property (@(posedge clk) disable iff (rst)
    (rpr_req_i && !ack_req_i && !nmi_ack_req_i && apr_nmi_o[1])
    |=> rd_data_o == {1'b1, 63'd0});
endmodule

// File: tb/vack_unit_tb.sv
module vack_unit_tb;
  import vack_pkg::*;
  localparam int unsigned NUM_LR  = 4;
  localparam int unsigned PREBITS = 5;
  localparam int unsigned IDX_W   = 2;
  localparam int unsigned NBITS   = 1 << PREBITS;
  localparam int unsigned SHIFT   = 8 - PREBITS;

  logic clk = 1'b0, rst = 1'b1;
  logic ack_req = 0, ack_grp = 0, nmi_ack_req = 0, rpr_req = 0;
  logic sel_valid = 0, sel_preempt = 0, nmi_en = 0;
  logic [IDX_W-1:0] sel_idx = '0;
  logic [NUM_LR*LR_W-1:0] lrs;
  logic rd_valid, lr_we;
  logic [63:0] rd_data;
  logic [IDX_W-1:0] lr_widx;
  logic [LR_W-1:0] lr_wdata;
  logic [NBITS-1:0] apr_g0, apr_g1;
  logic [1:0] apr_nmi;

  lr_t m_lr [NUM_LR];
  logic [NBITS-1:0] m_apr [2];
  logic [1:0] m_nmi;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  always_comb for (int i = 0; i < NUM_LR; i++) lrs[i*LR_W +: LR_W] = m_lr[i];

  vack_unit #(.NUM_LR(NUM_LR), .PREBITS(PREBITS)) u_dut (
    .clk(clk), .rst(rst), .ack_req_i(ack_req), .ack_grp_i(ack_grp),
    .nmi_ack_req_i(nmi_ack_req), .rpr_req_i(rpr_req), .sel_valid_i(sel_valid),
    .sel_idx_i(sel_idx), .sel_preempt_i(sel_preempt), .lrs_i(lrs),
    .nmi_en_i(nmi_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .lr_we_o(lr_we), .lr_widx_o(lr_widx), .lr_wdata_o(lr_wdata),
    .apr_g0_o(apr_g0), .apr_g1_o(apr_g1), .apr_nmi_o(apr_nmi));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic lr_t rand_lr();
    lr_t e;
    e.act  = 1'b0;
    e.pend = 1'b1;
    e.grp  = 1'($urandom % 2);
    e.nmi  = ($urandom % 10) < 3;
    e.prio = 8'($urandom);
    e.vid  = (($urandom % 5) == 0) ? ID_W'(1020 + ($urandom % 4)) : ID_W'($urandom % 1000);
    return e;
  endfunction

  function automatic logic [63:0] exp_rpr();
    logic [NBITS-1:0] b;
    if (m_nmi[1]) return {1'b1, 63'd0};
    b = m_apr[0] | m_apr[1];
    for (int k = 0; k < NBITS; k++) if (b[k]) return 64'(k << SHIFT);
    return 64'hFF;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {ack_req, nmi_ack_req, rpr_req} = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_apr[0] = '0; m_apr[1] = '0; m_nmi = '0;
    chk("R10 rd_valid", 64'(rd_valid), 64'd0);
    chk("R10 lr_we", 64'(lr_we), 64'd0);
    chk("R10 apr_g0", 64'(apr_g0), 64'd0);
    chk("R10 apr_g1", 64'(apr_g1), 64'd0);
    chk("R10 apr_nmi", 64'(apr_nmi), 64'd0);
  endtask

  // kind 0: ordinary ack, 1: NMI ack, 2: running-priority read. Called at a negedge.
  task automatic run_op(input int kind, input logic g, input logic sv, input int idx,
                        input logic cp, input logic ne);
    lr_t e, w;
    logic [63:0] exp_d;
    logic exp_we, hit, activate;
    string tag;
    e = m_lr[idx]; w = e; exp_we = 0; activate = 0;
    exp_d = 64'd1023; tag = "R1";
    if (kind == 2) begin
      exp_d = exp_rpr(); tag = "R8";
    end else begin
      hit = sv && cp && ((kind == 0) ? (e.grp == g) : e.grp);
      if (kind == 1) tag = "R7";
      if (hit) begin
        if (e.vid >= 1020 && e.vid <= 1023) begin
          exp_d = 64'(e.vid); exp_we = 1; w.pend = 0; tag = "R2";
        end else if (kind == 0 && ne && e.nmi) begin
          exp_d = 64'd1022; tag = "R3";
        end else if (kind == 1 && !e.nmi) begin
          exp_d = 64'd1023; tag = "R7";
        end else begin
          exp_d = 64'(e.vid); exp_we = 1; w.pend = 0; w.act = 1; activate = 1; tag = "R4";
        end
      end
    end
    ack_req = (kind == 0); nmi_ack_req = (kind == 1); rpr_req = (kind == 2);
    ack_grp = g; sel_valid = sv; sel_idx = IDX_W'(idx); sel_preempt = cp; nmi_en = ne;
    @(posedge clk);
    @(negedge clk);
    ack_req = 0; nmi_ack_req = 0; rpr_req = 0;
    if (activate) begin
      if (e.nmi) m_nmi[(kind == 1) ? 1 : g] = 1'b1;
      else m_apr[(kind == 1) ? 1 : g][e.prio >> SHIFT] = 1'b1;
    end
    chk({"R9 rd_valid ", tag}, 64'(rd_valid), 64'd1);
    chk({tag, " rd_data"}, rd_data, exp_d);
    chk({tag, " lr_we"}, 64'(lr_we), 64'(exp_we));
    if (exp_we) begin
      chk({tag, " lr_widx"}, 64'(lr_widx), 64'(idx));
      chk({tag, " lr_wdata"}, 64'(lr_wdata), 64'(w));
      m_lr[idx] = w;
    end
    chk({"R5 apr_g0 after ", tag}, 64'(apr_g0), 64'(m_apr[0]));
    chk({"R5 apr_g1 after ", tag}, 64'(apr_g1), 64'(m_apr[1]));
    chk({"R6 apr_nmi after ", tag}, 64'(apr_nmi), 64'(m_nmi));
  endtask

  function automatic lr_t mk(input logic grp, input logic nmi, input logic [7:0] p,
                             input int vid);
    lr_t e;
    e.act = 0; e.pend = 1; e.grp = grp; e.nmi = nmi; e.prio = p; e.vid = ID_W'(vid);
    return e;
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NUM_LR; i++) m_lr[i] = '0;
    m_apr[0] = '0; m_apr[1] = '0; m_nmi = '0;
    do_reset();
    // R8: empty banks read back 0xFF
    run_op(2, 0, 0, 0, 0, 0);
    // R1: invalid select, group mismatch, no preempt
    m_lr[0] = mk(1, 0, 8'h40, 33);
    run_op(0, 1, 0, 0, 1, 0);
    run_op(0, 0, 1, 0, 1, 0);
    run_op(0, 1, 1, 0, 0, 0);
    // R4/R5: group-1 activation, then R8 sees prio 0x40
    run_op(0, 1, 1, 0, 1, 0);
    run_op(2, 0, 0, 0, 0, 0);
    // R2: special ID clears pending only
    m_lr[1] = mk(0, 0, 8'h10, 1021);
    run_op(0, 0, 1, 1, 1, 0);
    // R3: NMI entry held with NMI enabled
    m_lr[2] = mk(1, 1, 8'h08, 77);
    run_op(0, 1, 1, 2, 1, 1);
    // R7: NMI ack on group-0 entry and on non-NMI entry
    m_lr[3] = mk(0, 1, 8'h08, 78);
    run_op(1, 0, 1, 3, 1, 1);
    m_lr[0] = mk(1, 0, 8'h20, 79);
    run_op(1, 0, 1, 0, 1, 1);
    // R6: NMI ack activates, then R8 reports NMI running priority
    run_op(1, 0, 1, 2, 1, 1);
    run_op(2, 0, 0, 0, 0, 0);
    // R6: ordinary ack with NMI disabled activates a group-0 NMI entry
    m_lr[3] = mk(0, 1, 8'hF0, 80);
    run_op(0, 0, 1, 3, 1, 0);
    do_reset();
    // R5: lowest slot wins for R8 across both groups
    m_lr[0] = mk(0, 0, 8'hF8, 5);
    m_lr[1] = mk(1, 0, 8'h18, 6);
    run_op(0, 0, 1, 0, 1, 0);
    run_op(0, 1, 1, 1, 1, 0);
    run_op(2, 0, 0, 0, 0, 0);
    // Random traffic
    for (int n = 0; n < 600; n++) begin
      int idx;
      if (n % 60 == 59) do_reset();
      idx = int'($urandom % NUM_LR);
      if (($urandom % 2) == 0 || !m_lr[idx].pend) m_lr[idx] = rand_lr();
      run_op(int'($urandom % 3), 1'($urandom % 2), ($urandom % 8) != 0, idx,
             ($urandom % 6) != 0, 1'($urandom % 2));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule